// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Command Receiver

This block is a receive-only target on a two-wire serial bus (I2C). It watches oversampled clock and data lines. It finds START and STOP conditions and collects a 7-bit target address followed by the direction bit. It answers with an acknowledge only when the address is its own and the direction is write. The top six address bits are fixed by a parameter. The lowest bit comes from a board-level select pin, so two copies can share one bus.

After an accepted address, each following byte is shifted in most significant bit first and acknowledged. The byte is then handed to the surrounding logic on `rxData`, together with a single-cycle `rxValid` strobe. Each byte is one tone command in the same coding used by a parallel command path elsewhere on the chip. The block never drives the data line high and never returns data. It does not stretch the clock.

Top module: `i2c_write_slave`

## Requirements
- R1: While and after reset, `sdaPullEn` and `rxValid` are low and `rxData` is zero.
- R2: A transfer whose first byte after START carries address `{ADDR_FIX, addrSel}` in bits 7..1 and a 0 in bit 0 is acknowledged: `sdaPullEn` is high while SCL is high in the ninth clock pulse.
- R3: If the address differs, or bit 0 (read) is 1, the ninth pulse is not acknowledged. No later byte is acknowledged or output until the next START.
- R4: Data bits are sampled on SCL rising edges, MSB first. Each complete byte appears on `rxData` with `rxValid` high for exactly one clock.
- R5: Every data byte of an accepted transfer is acknowledged in its ninth pulse.
- R6: `sdaPullEn` is asserted only in acknowledge slots. It is released within a few clocks after the ninth falling SCL edge, before the next rising edge.
- R7: A repeated START, at any point, restarts address reception. The new address alone decides whether the following bytes are accepted.
- R8: A STOP returns the receiver to idle. A partially received byte is discarded and produces no output.
- R9: `rxData` holds the last delivered byte until the next `rxValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Lowest address bit, strapped per device |
| sdaPullEn | output | 1 | Enables the open-drain pull-down on the data line |
| rxData | output | 8 | Last received command byte |
| rxValid | output | 1 | One-cycle strobe marking a new byte on `rxData` |

## Verification
If the state machine is in the wrong state, the error shows in the very next acknowledge slot. A pull-down appears where none belongs, or is missing after a matching address, within nine SCL pulses. A miscounted bit position or shifting on the wrong edge shows as a wrong byte at the next `rxValid` pulse. A missed START or STOP shows as lost or extra bytes when the following transfer's outputs are compared, one transfer later at most.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic cntClr;
    logic pullSet;
    logic pullClr;
    logic loadOut;
  } rxStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic evStart;
    logic evStop;
    logic sclRise;
    logic sclFall;
    logic byteFull;
    logic addrHit;
    logic rwBit;
  } rxStatus_t;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_rx_datapath.sv
module i2c_rx_datapath
  import i2c_rx_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          ADDR_FIX_W  = 6,
  parameter logic [ADDR_FIX_W-1:0] ADDR_FIX = 6'b010010,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  rxStrobe_t         strobe,
  output rxStatus_t         status,
  output logic              sdaPullEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);
  localparam int ADDR_W = ADDR_FIX_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic sclSync, sdaSync, sclPrev, sdaPrev;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              pullReg;
  logic [DATA_W-1:0] dataReg;
  logic              validReg;

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclSync));
  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  // bus events: edges of SCL, and SDA edges while SCL stays high
  always_comb begin
    status          = '0;
    status.sclRise  = sclSync & ~sclPrev;
    status.sclFall  = ~sclSync & sclPrev;
    status.evStart  = sclSync & sclPrev & sdaPrev & ~sdaSync;
    status.evStop   = sclSync & sclPrev & ~sdaPrev & sdaSync;
    status.byteFull = (bitCnt == CNT_FULL);
    status.addrHit  = (shiftReg[DATA_W-1 -: ADDR_W] == {ADDR_FIX, addrSel});
    status.rwBit    = shiftReg[0];
  end

  // shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (strobe.cntClr) begin
        bitCnt <= '0;
      end else if (strobe.shiftEn && (bitCnt != CNT_FULL)) begin
        shiftReg <= {shiftReg[DATA_W-2:0], sdaSync};
        bitCnt   <= bitCnt + 1'b1;
      end
    end
  end

  // open-drain pull and output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullReg  <= 1'b0;
      dataReg  <= '0;
      validReg <= 1'b0;
    end else begin
      if (strobe.pullClr)      pullReg <= 1'b0;
      else if (strobe.pullSet) pullReg <= 1'b1;
      if (strobe.loadOut) dataReg <= shiftReg;
      validReg <= strobe.loadOut;
    end
  end

  assign sdaPullEn = pullReg;
  assign rxData    = dataReg;
  assign rxValid   = validReg;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    validReg |=> !validReg); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validReg |-> $stable(dataReg)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_FULL); // R4
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  rxStatus_t status,
  output rxStrobe_t strobe,
  output rxState_t  state
);
  rxState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (status.evStop) begin
      stateNext      = ST_IDLE;
      strobe.pullClr = 1'b1;
    end else if (status.evStart) begin
      stateNext      = ST_ADDR;
      strobe.cntClr  = 1'b1;
      strobe.pullClr = 1'b1;
    end else begin
      case (state)
        ST_ADDR: begin
          strobe.shiftEn = status.sclRise;
          if (status.sclFall && status.byteFull) begin
            if (status.addrHit && !status.rwBit) begin
              stateNext      = ST_ADDR_ACK;
              strobe.pullSet = 1'b1;
            end else begin
              stateNext = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (status.sclFall) begin
            stateNext      = ST_DATA;
            strobe.pullClr = 1'b1;
            strobe.cntClr  = 1'b1;
          end
        end
        ST_DATA: begin
          strobe.shiftEn = status.sclRise;
          if (status.sclFall && status.byteFull) begin
            stateNext      = ST_DATA_ACK;
            strobe.pullSet = 1'b1;
            strobe.loadOut = 1'b1;
          end
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (status.evStart && !status.evStop) |=> (state == ST_ADDR)); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    status.evStop |=> (state == ST_IDLE)); // R8
  AST_IGNORE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && !status.evStart && !status.evStop) |=> (state == ST_IGNORE)); // R3
endmodule

// File: rtl/i2c_write_slave.sv
module i2c_write_slave
  import i2c_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_FIX_W  = 6,
  parameter logic [ADDR_FIX_W-1:0] ADDR_FIX = 6'b010010,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  output logic              sdaPullEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);
  rxStrobe_t strobe;
  rxStatus_t status;
  rxState_t  state;

  i2c_rx_datapath #(
    .DATA_W(DATA_W), .ADDR_FIX_W(ADDR_FIX_W),
    .ADDR_FIX(ADDR_FIX), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrSel(addrSel), .strobe(strobe), .status(status),
    .sdaPullEn(sdaPullEn), .rxData(rxData), .rxValid(rxValid));

  i2c_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .status(status),
    .strobe(strobe), .state(state));

  AST_PULL_IN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullEn |-> (state == ST_ADDR_ACK || state == ST_DATA_ACK)); // R6
  AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (state == ST_DATA_ACK)); // R5
endmodule

// File: tb/sim_i2c_write_slave.sv
`timescale 1ns/1ps
module sim_i2c_write_slave;
  localparam int Q = 6;
  localparam logic [5:0] FIX = 6'b010010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, addrSel = 1'b0;
  logic sdaPullEn, rxValid;
  logic [7:0] rxData;
  wire  sdaBus = sdaM & ~sdaPullEn;

  int chk = 0, bad = 0;
  int capN = 0, expN = 0, cmpN = 0;
  logic [7:0] capD [512];
  logic [7:0] expD [512];
  logic prevV = 1'b0;
  bit busIdle = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_write_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .addrSel(addrSel), .sdaPullEn(sdaPullEn), .rxData(rxData), .rxValid(rxValid));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chk++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // capture delivered bytes and check the strobe width
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        if (capN < 512) capD[capN] = rxData;
        capN++;
        if (prevV) check(1'b0, "R4 valid width", 2, 1);
      end
      prevV = rxValid;
    end
  end

  function automatic bit expAck(input logic [6:0] a, input logic rw, input logic sel);
    return (a == {FIX, sel}) && !rw;
  endfunction

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ();
  endtask

  task automatic startCond();
    if (busIdle) begin
      sdaM = 1'b1; sclM = 1'b1; waitQ();
    end else begin
      sdaM = 1'b1; waitQ();
      sclM = 1'b1; waitQ();
    end
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
    busIdle = 1'b0;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
    busIdle = 1'b1;
  endtask

  task automatic ackSlot(output bit ack);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    ack = sdaPullEn;
    waitQ();
    sclM = 1'b0; waitQ();
    check(sdaPullEn == 1'b0, "R6 release after ninth fall", sdaPullEn, 0);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    ackSlot(ack);
  endtask

  task automatic compareOutputs();
    check(capN == expN, "R4 byte count", capN, expN);
    for (int i = cmpN; i < expN && i < capN; i++)
      check(capD[i] == expD[i], "R4 byte value", capD[i], expD[i]);
    if (expN > 0)
      check(rxData == expD[expN-1], "R9 data held", rxData, expD[expN-1]);
    cmpN = expN;
    capN = expN;
  endtask

  // one address phase plus n data bytes; stop optional
  task automatic xfer(input logic [6:0] a, input logic rw, input int n,
                      input bit withStop, input bit randData, input logic [7:0] fixedB);
    bit ack, want;
    logic [7:0] b;
    want = expAck(a, rw, addrSel);
    startCond();
    sendByte({a, rw}, ack);
    if (want) check(ack == 1'b1, "R2 address ack", ack, 1);
    else      check(ack == 1'b0, "R3 address nack", ack, 0);
    for (int k = 0; k < n; k++) begin
      b = randData ? 8'($urandom) : (fixedB + 8'(k * 8'h5A));
      sendByte(b, ack);
      if (want) begin
        check(ack == 1'b1, "R5 data ack", ack, 1);
        expD[expN] = b; expN++;
      end else begin
        check(ack == 1'b0, "R3 ignored data", ack, 0);
      end
    end
    if (withStop) stopCond();
    waitQ();
    compareOutputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", chk, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [6:0] a;
    logic rw;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(sdaPullEn == 0 && rxValid == 0 && rxData == 0, "R1 in reset", {sdaPullEn, rxValid, rxData}, 0);
    rstN = 1'b1;
    waitQ(2);
    check(sdaPullEn == 0 && rxValid == 0 && rxData == 0, "R1 after reset", {sdaPullEn, rxValid, rxData}, 0);

    // R2 R4 R5: own address with selector low, edge byte values
    addrSel = 1'b0;
    xfer({FIX, 1'b0}, 1'b0, 3, 1'b1, 1'b0, 8'hA5);
    xfer({FIX, 1'b0}, 1'b0, 1, 1'b1, 1'b0, 8'hFF);
    xfer({FIX, 1'b0}, 1'b0, 1, 1'b1, 1'b0, 8'h00);
    // selector high
    addrSel = 1'b1;
    xfer({FIX, 1'b1}, 1'b0, 2, 1'b1, 1'b0, 8'h3C);
    // R3: neighbour address, read bit
    xfer({FIX, 1'b0}, 1'b0, 2, 1'b1, 1'b0, 8'h11);
    xfer({FIX, 1'b1}, 1'b1, 2, 1'b1, 1'b0, 8'h22);

    // R7: repeated start after ignored address, then after accepted data
    xfer(7'h13, 1'b0, 1, 1'b0, 1'b0, 8'h44);
    xfer({FIX, 1'b1}, 1'b0, 1, 1'b0, 1'b0, 8'h81);
    xfer({FIX, 1'b1}, 1'b0, 2, 1'b0, 1'b0, 8'h7E);
    xfer(7'h00, 1'b0, 1, 1'b1, 1'b0, 8'h99);

    // R8: stop in mid byte discards it, then next transfer works
    startCond();
    sendByte({FIX, 1'b1, 1'b0}, ack);
    check(ack == 1'b1, "R2 address ack before abort", ack, 1);
    for (int i = 0; i < 4; i++) bitOut(i[0]);
    stopCond();
    waitQ();
    compareOutputs();
    check(sdaPullEn == 1'b0, "R8 idle after stop", sdaPullEn, 0);
    xfer({FIX, 1'b1}, 1'b0, 1, 1'b1, 1'b0, 8'hC3);

    // random mix
    for (int t = 0; t < 30; t++) begin
      addrSel = 1'($urandom);
      case ($urandom % 4)
        0, 1:    a = {FIX, addrSel};
        2:       a = {FIX, ~addrSel};
        default: a = 7'($urandom);
      endcase
      rw = (($urandom % 4) == 0);
      xfer(a, rw, 1 + int'($urandom % 4), ($urandom % 3) != 0, 1'b1, 8'h00);
    end
    stopCond();
    waitQ();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", chk, bad);
    $finish;
  end
endmodule